// File: doc/BRIEF.md
# Event-Paced Three-Level Byte DMA Channel

This block is one DMA channel that copies bytes between memory and a peripheral data register. A hardware event line sets the pace. Software loads a parameter set through a small word-wide register port:

- a source address and a destination address;
- an inner byte count A, a middle count B and an outer count C;
- signed B and C strides for each side;
- a B reload value;
- a link word;
- an options word whose low bits hold a completion code.

Each event moves one array of A bytes. Source and destination each advance by their own B stride after an array. A frame is B arrays and the whole job is C frames. A stride of zero keeps one side fixed on a peripheral register while the other side walks a buffer: source stride 1 and destination stride 0 sends a buffer to the peripheral, and the opposite setting fills a buffer from it.

The channel is armed by writing the outer count. Software can poll that live count until it reads zero, or watch the one-cycle completion pulse. Events that arrive while an array is moving are queued. An event that cannot be served is recorded in a sticky missed flag.

Top module: `evt_dma_chan`

## Requirements
- R1: After reset the read and write strobes, the completion pulse and the missed flag are low, and register 3 reads 0.
- R2: One accepted event moves exactly A bytes. Byte k is read at source+k, and one cycle later it is written to destination+k with the data that came back from that read.
- R3: After an array that does not end a frame, each address advances by its own B stride (signed, 16-bit two's complement, wrapping at the address width), B count drops by one and C count is unchanged. A stride of 0 holds the address.
- R4: After the array that ends a frame (B count 1), B count takes the reload value, C count drops by one, and each address advances by its own C stride from the start of that last array.
- R5: Events that arrive while an array is in progress are queued, up to PEND_DEPTH waiting events, and are served one array each with no event lost.
- R6: When C count reaches 0, done_pulse is high for one cycle with done_code equal to bits [5:0] of the options word, and register 3 reads C count 0 in that same cycle.
- R7: evt_missed becomes set, and stays set, when an event arrives while C count is 0, when an event arrives while the queue already holds PEND_DEPTH events, or when events are still queued at completion. A write to register 3 clears it.
- R8: The register map is as follows, and reads return the live values:
  - 0: source address
  - 1: destination address
  - 2: {B count[31:16], A count[15:0]}
  - 3: {B reload[31:16], C count[15:0]}
  - 4: {destination B stride, source B stride}
  - 5: {destination C stride, source C stride}
  - 6: {link[31:16], options[15:0]}
  - 7: reads 0
- R9: An event that arrives while C count is 0 starts no read and no write.
- R10: After completion the channel issues no further reads until it is re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| dma_evt | input | 1 | Peripheral event, one per array |
| rd_en | output | 1 | Byte read strobe |
| rd_addr | output | 16 | Byte read address |
| rd_data | input | 8 | Read data, valid the cycle after rd_en |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 16 | Byte write address |
| wr_data | output | 8 | Byte write data |
| done_pulse | output | 1 | Transfer complete, one cycle |
| done_code | output | 6 | Completion code from the options word |
| evt_missed | output | 1 | Sticky missed-event flag |

## Verification
The hardest state to reach from the ports is a full event queue while an array is still moving, because events normally drain as fast as they come. The stimulus holds the event line high for seven cycles in a row against a four-byte array. Five events are accepted and two are refused while the queue is full, so the missed flag rises and the byte count shows how many arrays were served. Random parameter sets with mixed-sign strides are checked against a closed-form address formula. They push the frame-boundary C-stride step and address wraparound through many combinations.

// File: rtl/evt_dma_pkg.sv
package evt_dma_pkg;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int STR_W  = 16;
  localparam int CODE_W = 6;
  localparam int REG_W  = 32;
  localparam int RSEL_W = 3;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [STR_W-1:0]  str_t;

  localparam logic [RSEL_W-1:0] RG_SRC  = 3'd0;
  localparam logic [RSEL_W-1:0] RG_DST  = 3'd1;
  localparam logic [RSEL_W-1:0] RG_AB   = 3'd2;
  localparam logic [RSEL_W-1:0] RG_CRL  = 3'd3;
  localparam logic [RSEL_W-1:0] RG_BSTR = 3'd4;
  localparam logic [RSEL_W-1:0] RG_CSTR = 3'd5;
  localparam logic [RSEL_W-1:0] RG_LOPT = 3'd6;

  typedef enum logic [1:0] {MV_IDLE, MV_BUSY, MV_TAIL} mv_state_e;

  // address plus a signed stride, wrapping at the address width
  function automatic addr_t step_addr(input addr_t a, input str_t s);
    logic signed [ADDR_W+STR_W-1:0] ext;
    ext = $signed(s);
    return a + ext[ADDR_W-1:0];
  endfunction

  // address of byte k inside the current array
  function automatic addr_t byte_addr(input addr_t base, input cnt_t k);
    logic [ADDR_W+CNT_W-1:0] sum;
    sum = {{CNT_W{1'b0}}, base} + {{ADDR_W{1'b0}}, k};
    return sum[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/evt_dma_regs.sv
module evt_dma_regs
  import evt_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [RSEL_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              array_done,
  output logic              rearm,
  output addr_t             src,
  output addr_t             dst,
  output cnt_t              acnt,
  output cnt_t              bcnt,
  output cnt_t              ccnt,
  output logic              frame_end,
  output logic              xfer_end,
  output logic              done_pulse,
  output logic [CODE_W-1:0] done_code
);
  localparam int HALF = REG_W / 2;

  cnt_t brel;
  str_t sb_str, db_str, sc_str, dc_str;
  logic [HALF-1:0] link_w, opt_w;

  assign frame_end = array_done && (bcnt <= cnt_t'(1));
  assign xfer_end  = frame_end && (ccnt == cnt_t'(1));
  assign rearm     = cfg_we && (cfg_addr == RG_CRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0; dst <= '0; acnt <= '0; bcnt <= '0; ccnt <= '0; brel <= '0;
      sb_str <= '0; db_str <= '0; sc_str <= '0; dc_str <= '0;
      link_w <= '1; opt_w <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        RG_SRC:  src <= cfg_wdata[ADDR_W-1:0];
        RG_DST:  dst <= cfg_wdata[ADDR_W-1:0];
        RG_AB:   begin acnt <= cfg_wdata[CNT_W-1:0]; bcnt <= cfg_wdata[HALF+CNT_W-1:HALF]; end
        RG_CRL:  begin ccnt <= cfg_wdata[CNT_W-1:0]; brel <= cfg_wdata[HALF+CNT_W-1:HALF]; end
        RG_BSTR: begin sb_str <= cfg_wdata[STR_W-1:0]; db_str <= cfg_wdata[HALF+STR_W-1:HALF]; end
        RG_CSTR: begin sc_str <= cfg_wdata[STR_W-1:0]; dc_str <= cfg_wdata[HALF+STR_W-1:HALF]; end
        RG_LOPT: begin opt_w <= cfg_wdata[HALF-1:0]; link_w <= cfg_wdata[REG_W-1:HALF]; end
        default: ;
      endcase
    end else if (array_done) begin
      if (frame_end) begin
        bcnt <= brel;
        ccnt <= ccnt - cnt_t'(1);
        src  <= step_addr(src, sc_str);
        dst  <= step_addr(dst, dc_str);
      end else begin
        bcnt <= bcnt - cnt_t'(1);
        src  <= step_addr(src, sb_str);
        dst  <= step_addr(dst, db_str);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_pulse <= 1'b0;
      done_code  <= '0;
    end else begin
      done_pulse <= xfer_end;
      if (xfer_end) done_code <= opt_w[CODE_W-1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      RG_SRC:  cfg_rdata = REG_W'(src);
      RG_DST:  cfg_rdata = REG_W'(dst);
      RG_AB:   cfg_rdata = {HALF'(bcnt), HALF'(acnt)};
      RG_CRL:  cfg_rdata = {HALF'(brel), HALF'(ccnt)};
      RG_BSTR: cfg_rdata = {HALF'(db_str), HALF'(sb_str)};
      RG_CSTR: cfg_rdata = {HALF'(dc_str), HALF'(sc_str)};
      RG_LOPT: cfg_rdata = {link_w, opt_w};
      default: cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_dma_evq.sv
module evt_dma_evq #(
  parameter int DEPTH  = 4,
  localparam int PCNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              can_serve,
  input  logic              take,
  input  logic              flush,
  input  logic              clear,
  output logic [PCNT_W-1:0] pend,
  output logic              pend_nz,
  output logic              missed
);
  logic accept, miss_now;

  assign accept   = evt && can_serve && (pend < PCNT_W'(DEPTH));
  assign miss_now = (evt && !accept) || (flush && ((pend != '0) || accept));
  assign pend_nz  = (pend != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      missed <= 1'b0;
    end else begin
      if (clear || flush) pend <= '0;
      else                pend <= pend + PCNT_W'(accept) - PCNT_W'(take);
      if (clear)         missed <= 1'b0;
      else if (miss_now) missed <= 1'b1;
    end
  end
endmodule

// File: rtl/evt_dma_mover.sv
module evt_dma_mover
  import evt_dma_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go,
  input  addr_t src,
  input  addr_t dst,
  input  cnt_t  acnt,
  output logic  take,
  output logic  busy,
  output logic  rd_en,
  output addr_t rd_addr,
  output logic  wr_en,
  output addr_t wr_addr,
  output logic  array_done
);
  mv_state_e st;
  cnt_t      idx;
  logic      last_byte;

  assign last_byte  = (idx + cnt_t'(1)) >= acnt;
  assign take       = (st == MV_IDLE) && go;
  assign busy       = (st != MV_IDLE);
  assign rd_en      = (st == MV_BUSY);
  assign rd_addr    = byte_addr(src, idx);
  assign array_done = (st == MV_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= MV_IDLE;
      idx     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
    end else begin
      wr_en <= (st == MV_BUSY);
      if (st == MV_BUSY) wr_addr <= byte_addr(dst, idx);
      case (st)
        MV_IDLE: if (go) begin st <= MV_BUSY; idx <= '0; end
        MV_BUSY: if (last_byte) st <= MV_TAIL;
                 else idx <= idx + cnt_t'(1);
        default: st <= MV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evt_dma_chan.sv
module evt_dma_chan
  import evt_dma_pkg::*;
#(
  parameter int PEND_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [RSEL_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              dma_evt,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done_pulse,
  output logic [CODE_W-1:0] done_code,
  output logic              evt_missed
);
  localparam int PCNT_W = $clog2(PEND_DEPTH + 1);

  addr_t src, dst;
  cnt_t  acnt, bcnt, ccnt;
  logic  array_done, frame_end, xfer_end, rearm;
  logic  take, busy, pend_nz, go, live;
  logic [PCNT_W-1:0] pend;

  assign live    = (ccnt != '0);
  assign go      = pend_nz && live;
  assign wr_data = rd_data;

  evt_dma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .array_done(array_done),
    .rearm(rearm), .src(src), .dst(dst), .acnt(acnt), .bcnt(bcnt), .ccnt(ccnt),
    .frame_end(frame_end), .xfer_end(xfer_end), .done_pulse(done_pulse),
    .done_code(done_code)
  );

  evt_dma_evq #(.DEPTH(PEND_DEPTH)) u_evq (
    .clk(clk), .rst_n(rst_n), .evt(dma_evt), .can_serve(live), .take(take),
    .flush(xfer_end), .clear(rearm), .pend(pend), .pend_nz(pend_nz),
    .missed(evt_missed)
  );

  evt_dma_mover u_mv (
    .clk(clk), .rst_n(rst_n), .go(go), .src(src), .dst(dst), .acnt(acnt),
    .take(take), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .array_done(array_done)
  );
endmodule

// File: rtl/evt_dma_chan_chk.sv
module evt_dma_chan_chk
  import evt_dma_pkg::*;
#(
  parameter int PEND_DEPTH = 4,
  localparam int PCNT_W = $clog2(PEND_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [RSEL_W-1:0] cfg_addr,
  input logic              dma_evt,
  input logic              rd_en,
  input logic              wr_en,
  input logic              done_pulse,
  input logic              evt_missed,
  input logic              array_done,
  input logic              frame_end,
  input cnt_t              ccnt,
  input logic [PCNT_W-1:0] pend
);
  a_r2_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rd_en));

  a_r3_mid_frame_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
    (array_done && !frame_end && !cfg_we) |=> $stable(ccnt));

  a_r4_frame_end_drops_c: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !cfg_we) |=> (ccnt == $past(ccnt) - cnt_t'(1)));

  a_r5_queue_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PCNT_W'(PEND_DEPTH));

  a_r6_done_with_zero_c: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && !$past(cfg_we)) |-> (ccnt == '0));

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  a_r7_idle_event_missed: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_evt && (ccnt == '0) && !(cfg_we && cfg_addr == RG_CRL)) |=> evt_missed);

  a_r10_no_read_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |-> ($past(ccnt) != '0));
endmodule

bind evt_dma_chan evt_dma_chan_chk #(.PEND_DEPTH(PEND_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .dma_evt(dma_evt), .rd_en(rd_en), .wr_en(wr_en), .done_pulse(done_pulse),
  .evt_missed(evt_missed), .array_done(array_done), .frame_end(frame_end),
  .ccnt(ccnt), .pend(pend)
);

// File: tb/sim_evt_dma_chan.sv
`timescale 1ns/1ps
module sim_evt_dma_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        dma_evt = 1'b0;
  logic        rd_en, wr_en, done_pulse, evt_missed;
  logic [15:0] rd_addr, wr_addr;
  logic [7:0]  rd_data = '0;
  logic [7:0]  wr_data;
  logic [5:0]  done_code;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  evt_dma_chan u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dma_evt(dma_evt),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .done_pulse(done_pulse),
    .done_code(done_code), .evt_missed(evt_missed)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  // memory model and write log
  logic [15:0] wla [0:2047];
  logic [7:0]  wld [0:2047];
  int wn = 0;
  int dn = 0;
  logic [5:0] dcode = '0;
  always @(posedge clk) begin
    if (rd_en) rd_data <= pat(rd_addr);
    if (wr_en) begin
      if (wn < 2048) begin wla[wn] <= wr_addr; wld[wn] <= wr_data; end
      wn <= wn + 1;
    end
    if (done_pulse) begin dn <= dn + 1; dcode <= done_code; end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic fire();
    @(negedge clk); dma_evt = 1'b1;
    @(negedge clk); dma_evt = 1'b0;
  endtask

  task automatic burst(input int n);
    @(negedge clk); dma_evt = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); dma_evt = 1'b0;
  endtask

  // current parameter set in the bench
  int c_src, c_dst, c_a, c_b, c_c, c_sb, c_db, c_sc, c_dc, c_code;
  int log_base, done_base;

  task automatic program_set();
    cfg_wr(3'd0, 32'(c_src));
    cfg_wr(3'd1, 32'(c_dst));
    cfg_wr(3'd2, {16'(c_b), 16'(c_a)});
    cfg_wr(3'd4, {16'(c_db), 16'(c_sb)});
    cfg_wr(3'd5, {16'(c_dc), 16'(c_sc)});
    cfg_wr(3'd6, {16'hFFFF, 16'(c_code)});
    log_base  = wn;
    done_base = dn;
    cfg_wr(3'd3, {16'(c_b), 16'(c_c)});
  endtask

  // closed-form address of byte k of array i in frame f
  function automatic int addr_of(input int base, input int bs, input int cs,
                                 input int f, input int i, input int k);
    return (base + f * ((c_b - 1) * bs + cs) + i * bs + k) & 16'hFFFF;
  endfunction

  task automatic check_writes(input string req);
    int idx = 0;
    chk(req, "write count", wn - log_base, c_a * c_b * c_c);
    for (int f = 0; f < c_c; f++)
      for (int i = 0; i < c_b; i++)
        for (int k = 0; k < c_a; k++) begin
          int sa = addr_of(c_src, c_sb, c_sc, f, i, k);
          int da = addr_of(c_dst, c_db, c_dc, f, i, k);
          if (log_base + idx < wn) begin
            chk(req, "write addr", int'(wla[log_base + idx]), da);
            chk("R2", "write data", int'(wld[log_base + idx]), int'(pat(16'(sa))));
          end
          idx++;
        end
  endtask

  task automatic check_done();
    logic [31:0] d;
    chk("R6", "done pulses", dn - done_base, 1);
    chk("R6", "done code", int'(dcode), c_code & 6'h3F);
    cfg_rd(3'd3, d);
    chk("R6", "C count after done", int'(d[15:0]), 0);
    cfg_rd(3'd0, d);
    chk("R4", "final source", int'(d[15:0]), addr_of(c_src, c_sb, c_sc, c_c, 0, 0));
    cfg_rd(3'd1, d);
    chk("R4", "final destination", int'(d[15:0]), addr_of(c_dst, c_db, c_dc, c_c, 0, 0));
    cfg_rd(3'd2, d);
    chk("R4", "B reloaded", int'(d[31:16]), c_b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int wsave;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rd_en", int'(rd_en), 0);
    chk("R1", "wr_en", int'(wr_en), 0);
    chk("R1", "done_pulse", int'(done_pulse), 0);
    chk("R1", "evt_missed", int'(evt_missed), 0);
    cfg_rd(3'd3, d);
    chk("R1", "C count", int'(d), 0);

    // R3 buffer to fixed peripheral register
    c_src = 16'h0100; c_dst = 16'h8000; c_a = 1; c_b = 8; c_c = 1;
    c_sb = 1; c_db = 0; c_sc = 0; c_dc = 0; c_code = 5;
    program_set();
    cfg_rd(3'd4, d);
    chk("R8", "B stride readback", int'(d), 32'h0000_0001);
    cfg_rd(3'd6, d);
    chk("R8", "link/options readback", int'(d), 32'hFFFF_0005);
    for (int e = 0; e < 8; e++) begin fire(); repeat (6) @(negedge clk); end
    check_writes("R3");
    check_done();
    // R9 event with nothing left
    wsave = wn;
    fire(); repeat (8) @(negedge clk);
    chk("R9", "no writes when idle", wn - wsave, 0);
    chk("R7", "missed after idle event", int'(evt_missed), 1);
    chk("R10", "no extra done", dn - done_base, 1);

    // R5 peripheral to buffer, back-to-back events
    c_src = 16'h9000; c_dst = 16'h0200; c_a = 2; c_b = 4; c_c = 1;
    c_sb = 0; c_db = 2; c_sc = 0; c_dc = 0; c_code = 6'h2A;
    program_set();
    chk("R7", "missed cleared by rearm", int'(evt_missed), 0);
    burst(4);
    repeat (25) @(negedge clk);
    check_writes("R5");
    check_done();
    chk("R5", "no miss on queued burst", int'(evt_missed), 0);

    // R7 queue overflow: 7 events in a row, 5 accepted
    c_src = 16'h0400; c_dst = 16'h0600; c_a = 4; c_b = 8; c_c = 1;
    c_sb = 4; c_db = 4; c_sc = 0; c_dc = 0; c_code = 3;
    program_set();
    burst(7);
    repeat (40) @(negedge clk);
    chk("R5", "bytes after overflow burst", wn - log_base, 20);
    chk("R7", "missed on full queue", int'(evt_missed), 1);
    for (int e = 0; e < 3; e++) begin fire(); repeat (8) @(negedge clk); end
    check_writes("R5");
    check_done();

    // R4 random three-level sets
    void'($urandom(32'd4242));
    for (int t = 0; t < 8; t++) begin
      c_a = $urandom_range(1, 4); c_b = $urandom_range(1, 4); c_c = $urandom_range(1, 3);
      c_src = $urandom_range(16'h1000, 16'h2000);
      c_dst = (t == 7) ? 16'hFFFE : $urandom_range(16'h3000, 16'h4000);
      c_sb = $urandom_range(0, 16) - 8; c_db = $urandom_range(0, 16) - 8;
      c_sc = $urandom_range(0, 40) - 20; c_dc = $urandom_range(0, 40) - 20;
      c_code = $urandom_range(0, 63);
      program_set();
      cfg_rd(3'd5, d);
      chk("R8", "C stride readback", int'(d), int'({16'(c_dc), 16'(c_sc)}));
      for (int e = 0; e < c_b * c_c; e++) begin
        fire();
        repeat ($urandom_range(c_a, c_a + 4)) @(negedge clk);
      end
      repeat (12) @(negedge clk);
      check_writes("R4");
      check_done();
      chk("R7", "no miss at paced rate", int'(evt_missed), 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule